// File: doc/BRIEF.md
# Multiphase Token-Ring Phase Activator

This block decides when each phase of a multiphase buck regulator starts a charging cycle. A single activation token moves around a ring of per-phase stages. The token moves on when an internal period timer expires, so no separate phase-activation clock is needed. While a stage holds the token and the under-voltage indication is present, the block sends that phase's sequencer a one-cycle start request. The block does not wait for the charging cycle of a phase to end before the token moves on, so the charging cycles of neighbouring phases can overlap.

A high-load input switches the block into a second mode. In that mode every phase receives its start request in the same cycle. The token stays where it is during high-load mode. When high-load mode ends, normal rotation continues from the phase after the one that held the token. The number of phases (three in the example) and the timer period (40 cycles, which is 200 ns at 200 MHz) are parameters. The per-phase switch sequencing, the comparators and the power stage are outside this block.

Top module: `phase_ring_activator`

## Requirements
- R1: For the cycle after a cycle with `rst` high, `start_req` is all zero and `all_phase_mode` is 0. The token sits at phase 0, so the first activation in normal mode goes to bit 0 of `start_req`.
- R2: In normal mode the token stays at each stage for exactly `PERIOD_CYC` cycles and then moves to the next stage. A mode change restarts this count.
- R3: Normal-mode activations follow the ring order 0, 1, …, `NUM_PH`-1, 0. Bit i of `start_req` belongs to phase i.
- R4: A stage is activated when `uv_low` is sampled high while the stage holds the token. The stage is activated at most once per holding slot. It is not activated in the last cycle of the slot. The pulse appears on the clock edge after the one that sampled `uv_low` and lasts one cycle.
- R5: If `uv_low` stays low, no start request is issued, and the token still moves on at the end of each period.
- R6: In high-load mode, every bit of `start_req` is set in the same cycle. This happens at most once per period slot, under the same `uv_low` conditions as R4.
- R7: `all_phase_mode` equals `high_load` delayed by one clock. In the cycle where `high_load` differs from `all_phase_mode`, no request is issued.
- R8: The token does not move during high-load mode. When high-load mode ends, the token moves one stage on, so normal rotation continues from the phase after the last holder.
- R9: In normal mode at most one bit of `start_req` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_low | input | 1 | Under-voltage indication (output below reference) |
| high_load | input | 1 | Request for all-phases-together mode |
| start_req | output | NUM_PH | One-cycle start request per phase, registered |
| all_phase_mode | output | 1 | High while the block is in high-load mode |

## Verification
The bench targets the corner cases where a wrong design fails in a visible way. The first is an activation requested in the last cycle of a slot: a design that wrongly allowed it would issue two requests back to back. The second is `uv_low` held low for several periods: a design that freezes the token would then fire the wrong phase when `uv_low` returns. The third is high-load entry and exit in the middle of a slot: a design that drops the one-stage advance on exit, or lets the token move during high-load, would send the next normal request to the wrong phase. The fourth is `high_load` toggled on successive cycles, which would expose a missing slot restart or a request issued on a mode-change cycle.

// File: rtl/pra_pkg.sv
package pra_pkg;
  typedef enum logic {
    MODE_ROTATE = 1'b0,
    MODE_ALL    = 1'b1
  } pra_mode_e;
endpackage

// File: rtl/pra_timer.sv
module pra_timer #(
  parameter int PERIOD_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) cnt <= '0;
    else                        cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/pra_ring.sv
module pra_ring #(
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [NUM_PH-1:0] tok
);
  for (genvar i = 0; i < NUM_PH; i++) begin : g_stage
    localparam int PREV = (i + NUM_PH - 1) % NUM_PH;
    always_ff @(posedge clk) begin
      if (rst)          tok[i] <= (i == 0);
      else if (advance) tok[i] <= tok[PREV];
    end
  end
endmodule

// File: rtl/pra_issue.sv
module pra_issue #(
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  pra_pkg::pra_mode_e mode,
  input  logic [NUM_PH-1:0] tok,
  output logic [NUM_PH-1:0] start_req
);
  for (genvar i = 0; i < NUM_PH; i++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) start_req[i] <= 1'b0;
      else     start_req[i] <= fire && ((mode == pra_pkg::MODE_ALL) || tok[i]);
    end
  end
endmodule

// File: rtl/phase_ring_activator.sv
module phase_ring_activator #(
  parameter int NUM_PH     = 3,
  parameter int PERIOD_CYC = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uv_low,
  input  logic              high_load,
  output logic [NUM_PH-1:0] start_req,
  output logic              all_phase_mode
);
  import pra_pkg::*;

  pra_mode_e         mode_q;
  logic              fired_q;
  logic              tick;
  logic              mode_chg;
  logic              fire;
  logic              advance;
  logic [NUM_PH-1:0] tok;

  assign mode_chg = (high_load != (mode_q == MODE_ALL));
  assign fire     = uv_low && !fired_q && !tick && !mode_chg;
  assign advance  = mode_chg ? (mode_q == MODE_ALL)
                             : (tick && (mode_q == MODE_ROTATE));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_ROTATE;
      fired_q <= 1'b0;
    end else begin
      mode_q  <= high_load ? MODE_ALL : MODE_ROTATE;
      fired_q <= (tick || mode_chg) ? 1'b0 : (fired_q || fire);
    end
  end

  assign all_phase_mode = (mode_q == MODE_ALL);

  pra_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk(clk), .rst(rst), .restart(mode_chg), .tick(tick)
  );

  pra_ring #(.NUM_PH(NUM_PH)) u_ring (
    .clk(clk), .rst(rst), .advance(advance), .tok(tok)
  );

  pra_issue #(.NUM_PH(NUM_PH)) u_issue (
    .clk(clk), .rst(rst), .fire(fire), .mode(mode_q), .tok(tok),
    .start_req(start_req)
  );
endmodule

// File: rtl/pra_checker.sv
module pra_checker #(
  parameter int NUM_PH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              high_load,
  input logic [NUM_PH-1:0] start_req,
  input logic              all_phase_mode,
  input logic [NUM_PH-1:0] tok,
  input logic              tick
);
  function automatic logic [NUM_PH-1:0] rot(input logic [NUM_PH-1:0] t);
    rot = (t << 1) | (t >> (NUM_PH - 1));
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (start_req == '0) && !all_phase_mode && (tok == NUM_PH'(1)));

  // R3
  tok_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(tok));

  // R2
  tok_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !all_phase_mode && !high_load) |=> (tok == rot($past(tok))));

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (|start_req) |=> (start_req == '0));

  // R6
  all_together_chk: assert property (@(posedge clk) disable iff (rst)
    (all_phase_mode && (|start_req)) |-> (&start_req));

  // R7
  mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (all_phase_mode == $past(high_load)));

  // R8
  tok_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (all_phase_mode && high_load) |=> $stable(tok));

  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    !all_phase_mode |-> ($countones(start_req) <= 1));
endmodule

bind phase_ring_activator pra_checker #(.NUM_PH(NUM_PH)) u_pra_chk (
  .clk(clk), .rst(rst), .high_load(high_load), .start_req(start_req),
  .all_phase_mode(all_phase_mode), .tok(tok), .tick(tick)
);

// File: tb/tb_phase_ring_activator.sv
module tb_phase_ring_activator;
  localparam int N = 3;
  localparam int P = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         uv_low = 1'b0;
  logic         high_load = 1'b0;
  logic [N-1:0] start_req;
  logic         all_phase_mode;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  phase_ring_activator #(.NUM_PH(N), .PERIOD_CYC(P)) dut (
    .clk(clk), .rst(rst), .uv_low(uv_low), .high_load(high_load),
    .start_req(start_req), .all_phase_mode(all_phase_mode)
  );

  // reference state, from the requirements
  int           m_hold = 0;
  int           m_cnt = 0;
  bit           m_fired = 0;
  bit           m_mode = 0;
  logic [N-1:0] exp_req = '0;
  bit           exp_mode = 0;
  bit           exp_valid = 0;
  string        tag = "R1";
  logic [15:0]  lfsr = 16'hACE1;

  task automatic compare();
    n_cmp++;
    if (start_req !== exp_req || all_phase_mode !== exp_mode) begin
      n_bad++;
      $display("FAIL %s t=%0t start_req=%b mode=%b expected start_req=%b mode=%b",
               tag, $time, start_req, all_phase_mode, exp_req, exp_mode);
    end
  endtask

  task automatic step(input bit uv, input bit hl, input bit r);
    bit chg, tk, fr;
    @(negedge clk);
    if (exp_valid) compare();
    uv_low = uv; high_load = hl; rst = r;
    if (r) begin
      m_hold = 0; m_cnt = 0; m_fired = 0; m_mode = 0;
      exp_req = '0; exp_mode = 0;
    end else begin
      chg = (hl != m_mode);
      tk  = (m_cnt == P - 1);
      fr  = uv && !m_fired && !tk && !chg;
      exp_req  = fr ? (m_mode ? {N{1'b1}} : (N'(1) << m_hold)) : '0;
      exp_mode = hl;
      if (chg) begin
        if (m_mode) m_hold = (m_hold + 1) % N;
        m_cnt = 0; m_fired = 0;
      end else if (tk) begin
        if (!m_mode) m_hold = (m_hold + 1) % N;
        m_cnt = 0; m_fired = 0;
      end else begin
        m_cnt++; m_fired = m_fired | fr;
      end
      m_mode = hl;
    end
    exp_valid = 1;
    @(posedge clk);
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] v);
    nxt = {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state and first activation at phase 0
    tag = "R1";
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    for (int i = 0; i < 4; i++) step(1, 0, 0);
    // R3: continuous demand, several laps of the ring
    tag = "R3";
    for (int i = 0; i < 6 * N * P; i++) step(1, 0, 0);
    // R5: no demand, token keeps moving, then demand returns
    tag = "R5";
    for (int i = 0; i < 5 * P + 1; i++) step(0, 0, 0);
    for (int i = 0; i < 2 * P; i++) step(1, 0, 0);
    // R4: one-cycle demand at every offset in the slot, incl. last cycle
    tag = "R4";
    for (int off = 0; off < 2 * P; off++) begin
      for (int j = 0; j < N * P; j++) step(j == off, 0, 0);
    end
    // R2: demand with sparse pseudo-random pattern
    tag = "R2";
    for (int i = 0; i < 120; i++) begin
      lfsr = nxt(lfsr);
      step(lfsr[0] & lfsr[3], 0, 0);
    end
    // R6: high-load with continuous demand
    tag = "R6";
    for (int i = 0; i < 5 * P; i++) step(1, 1, 0);
    // R8: exit high-load, rotation resumes after last holder
    tag = "R8";
    for (int i = 0; i < 3 * N * P; i++) step(1, 0, 0);
    for (int k = 0; k < 2 * P; k++) begin
      for (int i = 0; i < k + 1; i++) step(1, 0, 0);
      for (int i = 0; i < P + k; i++) step(k[0], 1, 0);
    end
    // R7: mode toggling on successive cycles
    tag = "R7";
    for (int i = 0; i < 24; i++) step(1, i[0], 0);
    for (int i = 0; i < 24; i++) step(1, i[1], 0);
    // R1: reset in the middle of activity
    tag = "R1";
    step(1, 1, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    // R9: long mixed sweep of both inputs
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      lfsr = nxt(lfsr);
      step(lfsr[1], (lfsr[15:12] > 4'd10) ? lfsr[2] : high_load, 0);
    end
    step(0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule